// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the hardwired sequencer of a multicycle load/store processor. The datapath has one shared ALU and a set of holding registers: the instruction register, two operand latches, the ALU result latch and the memory data latch. Each clock cycle the controller reads the current 6-bit opcode from the instruction register and the ALU flags. From its own state it drives every datapath strobe and multiplexer select. Each instruction class takes its own path of states: register-register ALU operations, OR with a zero-extended immediate, word load, word store and branch-if-equal. Every path starts with a common fetch cycle and a common decode cycle and ends by returning to fetch.

Two trap states deal with faults. One handles an opcode that decode does not recognise. The other handles an arithmetic overflow reported during register-register execute. A trap state has the ALU form the faulting instruction's address (the already advanced PC minus 4) and strobes it into the exception PC register. It records a cause code and steers the PC to the fixed handler entry. The datapath, memory and register file sit outside the block.

Top module: `mc_ctrl`

## Requirements
- R1: While `rst_n` is low, `state` is 0000 and all strobes (`pc_load`, `pc_wr`, `pc_wr_cond`, `ir_wr`, `reg_wr`, `mem_rd`, `mem_wr`, `epc_wr`, `cause_wr`) are 0. Release is synchronised: the fetch state drives its strobes only from the second rising edge after `rst_n` goes high. The state leaves fetch on the third rising edge.
- R2: State 0000 (fetch) drives `mem_rd`=1, `iord`=0 (address from PC), `ir_wr`=1, `alu_src_a`=0 (PC), `alu_src_b`=1 (constant 4), `alu_op`=0 (add), `pc_src`=0 (ALU result) and `pc_wr`=1. In every state, any output not listed for that state is 0.
- R3: State 0001 (decode) drives `alu_src_a`=0 and `alu_src_b`=3 (sign-extended immediate shifted left 2) with `alu_op`=0. It always follows fetch. Its successor is chosen by opcode: 0 goes to 0100, 13 to 0110, 35 to 1000, 43 to 1011, 4 to 0010, and any other opcode to 1101.
- R4: State 0100 drives `alu_src_a`=1 (A), `alu_src_b`=0 (B) and `alu_op`=2 (function field). Without overflow it goes to 0101, which drives `reg_wr`=1 and `reg_dst`=1 (rd) with `mem_to_reg`=0.
- R5: State 0110 drives `alu_src_a`=1, `alu_src_b`=4 (zero-extended immediate) and `alu_op`=3 (OR). It goes to 0111, which drives `reg_wr`=1 and `reg_dst`=0 (rt).
- R6: State 1000 drives `alu_src_a`=1, `alu_src_b`=2 (sign-extended immediate) and `alu_op`=0. It goes to 1001, which drives `mem_rd`=1 and `iord`=1 (address from ALUout). That is followed by 1010, which drives `reg_wr`=1, `reg_dst`=0 and `mem_to_reg`=1.
- R7: State 1011 drives the same ALU selects as 1000. It goes to 1100, which drives `mem_wr`=1 and `iord`=1.
- R8: State 0010 drives `alu_src_a`=1, `alu_src_b`=0, `alu_op`=1 (subtract), `pc_wr_cond`=1 and `pc_src`=1 (ALUout). In every state `pc_load` equals `pc_wr` OR (`pc_wr_cond` AND `alu_zero`).
- R9: Counting from fetch, an instruction takes 3 cycles for branch, 4 for register-register, OR-immediate and store, and 5 for load. A trap on an undefined opcode takes 3 cycles and a trap on overflow takes 4.
- R10: An undefined opcode enters state 1101. That state drives `alu_src_a`=0, `alu_src_b`=1, `alu_op`=1 (PC−4), `epc_wr`=1, `cause_wr`=1, `cause_code`=00, `pc_src`=2 (handler address) and `pc_wr`=1.
- R11: `alu_ovf` high in state 0100 enters state 1110 instead of 0101. State 1110 drives the same outputs as 1101 except `cause_code`=01. No `reg_wr` follows the overflowing execute.
- R12: States 0010, 0101, 0111, 1010, 1100, 1101 and 1110 always return to fetch on the next edge.
- R13: `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| alu_ovf | input | 1 | ALU signed overflow flag |
| pc_load | output | 1 | Combined PC load enable |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by zero flag |
| pc_src | output | 2 | PC source: 0 ALU, 1 ALUout, 2 handler |
| ir_wr | output | 1 | Instruction register write |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination select: 0 rt, 1 rd |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| iord | output | 1 | Memory address: 0 PC, 1 ALUout |
| alu_src_a | output | 1 | ALU A: 0 PC, 1 A latch |
| alu_src_b | output | 3 | ALU B: 0 B, 1 four, 2 sext imm, 3 sext imm<<2, 4 zext imm |
| alu_op | output | 2 | 0 add, 1 subtract, 2 function field, 3 OR |
| mem_to_reg | output | 1 | Write-back data: 0 ALUout, 1 MDR |
| epc_wr | output | 1 | Exception PC register write |
| cause_wr | output | 1 | Cause register write |
| cause_code | output | 2 | Cause value, low bit 0 undefined, 1 overflow |
| state | output | 4 | Current controller state code |

## Verification
The bench builds the controller with the default two-stage reset synchroniser and the 6-bit opcode. This lets it sweep all 64 opcodes, each with overflow and zero flags both low and both high. That covers every decode successor and the full undefined-opcode space. It also covers both branch outcomes and both register-register outcomes. It compares every cycle's complete control word and the path length against values it derives from the state table. A separate sequence drops reset in the middle of a load and counts the edges before fetch regains its strobes.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int OPC_W   = 6;
  localparam int STATE_W = 4;
  localparam int CAUSE_W = 2;
  localparam int SRCB_W  = 3;
  localparam int AOP_W   = 2;
  localparam int PCS_W   = 2;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'd0;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd4;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH     = 4'b0000,
    ST_DECODE    = 4'b0001,
    ST_BEQ       = 4'b0010,
    ST_REXE      = 4'b0100,
    ST_RWB       = 4'b0101,
    ST_ORIEXE    = 4'b0110,
    ST_ORIWB     = 4'b0111,
    ST_LDADDR    = 4'b1000,
    ST_LDMEM     = 4'b1001,
    ST_LDWB      = 4'b1010,
    ST_STADDR    = 4'b1011,
    ST_STMEM     = 4'b1100,
    ST_EXC_UNDEF = 4'b1101,
    ST_EXC_OVF   = 4'b1110
  } ctrl_state_e;

  typedef enum logic [2:0] {
    CL_RTYPE, CL_ORI, CL_LOAD, CL_STORE, CL_BEQ, CL_UNDEF
  } instr_class_e;

  localparam logic [PCS_W-1:0]  PCS_ALU     = 2'd0;
  localparam logic [PCS_W-1:0]  PCS_ALUOUT  = 2'd1;
  localparam logic [PCS_W-1:0]  PCS_HANDLER = 2'd2;
  localparam logic [SRCB_W-1:0] SB_B        = 3'd0;
  localparam logic [SRCB_W-1:0] SB_FOUR     = 3'd1;
  localparam logic [SRCB_W-1:0] SB_SEXT     = 3'd2;
  localparam logic [SRCB_W-1:0] SB_SEXT_SH  = 3'd3;
  localparam logic [SRCB_W-1:0] SB_ZEXT     = 3'd4;
  localparam logic [AOP_W-1:0]  AOP_ADD     = 2'd0;
  localparam logic [AOP_W-1:0]  AOP_SUB     = 2'd1;
  localparam logic [AOP_W-1:0]  AOP_FUNCT   = 2'd2;
  localparam logic [AOP_W-1:0]  AOP_OR      = 2'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_UNDEF = 2'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_OVF   = 2'd1;

  typedef struct packed {
    logic               pc_wr;
    logic               pc_wr_cond;
    logic [PCS_W-1:0]   pc_src;
    logic               ir_wr;
    logic               reg_wr;
    logic               reg_dst;
    logic               mem_rd;
    logic               mem_wr;
    logic               iord;
    logic               alu_src_a;
    logic [SRCB_W-1:0]  alu_src_b;
    logic [AOP_W-1:0]   alu_op;
    logic               mem_to_reg;
    logic               epc_wr;
    logic               cause_wr;
    logic [CAUSE_W-1:0] cause_code;
  } ctrl_word_t;

endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES < 2) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign run = sync_q[STAGES-1];
endmodule

// File: rtl/mc_op_decode.sv
module mc_op_decode
  import mc_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output instr_class_e     cls
);
  always_comb begin
    case (opcode)
      OPC_RTYPE: cls = CL_RTYPE;
      OPC_ORI:   cls = CL_ORI;
      OPC_LOAD:  cls = CL_LOAD;
      OPC_STORE: cls = CL_STORE;
      OPC_BEQ:   cls = CL_BEQ;
      default:   cls = CL_UNDEF;
    endcase
  end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  logic         clk,
  input  logic         run,
  input  instr_class_e cls,
  input  logic         alu_ovf,
  output ctrl_state_e  cur
);
  ctrl_state_e nxt;

  always_comb begin
    nxt = ST_FETCH;
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        case (cls)
          CL_RTYPE: nxt = ST_REXE;
          CL_ORI:   nxt = ST_ORIEXE;
          CL_LOAD:  nxt = ST_LDADDR;
          CL_STORE: nxt = ST_STADDR;
          CL_BEQ:   nxt = ST_BEQ;
          default:  nxt = ST_EXC_UNDEF;
        endcase
      end
      ST_REXE:   nxt = alu_ovf ? ST_EXC_OVF : ST_RWB;
      ST_ORIEXE: nxt = ST_ORIWB;
      ST_LDADDR: nxt = ST_LDMEM;
      ST_LDMEM:  nxt = ST_LDWB;
      ST_STADDR: nxt = ST_STMEM;
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge run) begin
    if (!run) cur <= ST_FETCH;
    else      cur <= nxt;
  end

  // R3
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!run)
    cur == ST_FETCH |=> cur == ST_DECODE);

  // R10
  undef_trap_chk: assert property (@(posedge clk) disable iff (!run)
    (cur == ST_DECODE && cls == CL_UNDEF) |=> cur == ST_EXC_UNDEF);

  // R11
  ovf_trap_chk: assert property (@(posedge clk) disable iff (!run)
    (cur == ST_REXE && alu_ovf) |=> cur == ST_EXC_OVF);

  // R12
  terminal_return_chk: assert property (@(posedge clk) disable iff (!run)
    (cur inside {ST_BEQ, ST_RWB, ST_ORIWB, ST_LDWB, ST_STMEM,
                 ST_EXC_UNDEF, ST_EXC_OVF}) |=> cur == ST_FETCH);
endmodule

// File: rtl/mc_out_decode.sv
module mc_out_decode
  import mc_ctrl_pkg::*;
(
  input  ctrl_state_e cur,
  input  logic        run,
  output ctrl_word_t  ctl
);
  ctrl_word_t raw;

  always_comb begin
    raw = '0;
    case (cur)
      ST_FETCH: begin
        raw.mem_rd    = 1'b1;
        raw.ir_wr     = 1'b1;
        raw.alu_src_b = SB_FOUR;
        raw.alu_op    = AOP_ADD;
        raw.pc_src    = PCS_ALU;
        raw.pc_wr     = 1'b1;
      end
      ST_DECODE: raw.alu_src_b = SB_SEXT_SH;
      ST_BEQ: begin
        raw.alu_src_a  = 1'b1;
        raw.alu_src_b  = SB_B;
        raw.alu_op     = AOP_SUB;
        raw.pc_wr_cond = 1'b1;
        raw.pc_src     = PCS_ALUOUT;
      end
      ST_REXE: begin
        raw.alu_src_a = 1'b1;
        raw.alu_op    = AOP_FUNCT;
      end
      ST_RWB: begin
        raw.reg_wr  = 1'b1;
        raw.reg_dst = 1'b1;
      end
      ST_ORIEXE: begin
        raw.alu_src_a = 1'b1;
        raw.alu_src_b = SB_ZEXT;
        raw.alu_op    = AOP_OR;
      end
      ST_ORIWB: raw.reg_wr = 1'b1;
      ST_LDADDR, ST_STADDR: begin
        raw.alu_src_a = 1'b1;
        raw.alu_src_b = SB_SEXT;
      end
      ST_LDMEM: begin
        raw.mem_rd = 1'b1;
        raw.iord   = 1'b1;
      end
      ST_LDWB: begin
        raw.reg_wr     = 1'b1;
        raw.mem_to_reg = 1'b1;
      end
      ST_STMEM: begin
        raw.mem_wr = 1'b1;
        raw.iord   = 1'b1;
      end
      ST_EXC_UNDEF, ST_EXC_OVF: begin
        raw.alu_src_b  = SB_FOUR;
        raw.alu_op     = AOP_SUB;
        raw.epc_wr     = 1'b1;
        raw.cause_wr   = 1'b1;
        raw.cause_code = (cur == ST_EXC_OVF) ? CAUSE_OVF : CAUSE_UNDEF;
        raw.pc_src     = PCS_HANDLER;
        raw.pc_wr      = 1'b1;
      end
      default: raw = '0;
    endcase
  end

  always_comb begin
    ctl = raw;
    if (!run) begin
      ctl.pc_wr      = 1'b0;
      ctl.pc_wr_cond = 1'b0;
      ctl.ir_wr      = 1'b0;
      ctl.reg_wr     = 1'b0;
      ctl.mem_rd     = 1'b0;
      ctl.mem_wr     = 1'b0;
      ctl.epc_wr     = 1'b0;
      ctl.cause_wr   = 1'b0;
    end
  end

  // R13
  always_comb begin
    if (run) begin
      mem_excl_chk: assert (!(ctl.mem_rd && ctl.mem_wr));
    end
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OPC_W-1:0]    opcode,
  input  logic                alu_zero,
  input  logic                alu_ovf,
  output logic                pc_load,
  output logic                pc_wr,
  output logic                pc_wr_cond,
  output logic [PCS_W-1:0]    pc_src,
  output logic                ir_wr,
  output logic                reg_wr,
  output logic                reg_dst,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                iord,
  output logic                alu_src_a,
  output logic [SRCB_W-1:0]   alu_src_b,
  output logic [AOP_W-1:0]    alu_op,
  output logic                mem_to_reg,
  output logic                epc_wr,
  output logic                cause_wr,
  output logic [CAUSE_W-1:0]  cause_code,
  output logic [STATE_W-1:0]  state
);
  logic         run;
  instr_class_e cls;
  ctrl_state_e  cur;
  ctrl_word_t   ctl;

  mc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .run(run));

  mc_op_decode u_dec (.opcode(opcode), .cls(cls));

  mc_next_state u_ns (
    .clk(clk), .run(run), .cls(cls), .alu_ovf(alu_ovf), .cur(cur));

  mc_out_decode u_out (.cur(cur), .run(run), .ctl(ctl));

  assign pc_wr      = ctl.pc_wr;
  assign pc_wr_cond = ctl.pc_wr_cond;
  assign pc_src     = ctl.pc_src;
  assign ir_wr      = ctl.ir_wr;
  assign reg_wr     = ctl.reg_wr;
  assign reg_dst    = ctl.reg_dst;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign iord       = ctl.iord;
  assign alu_src_a  = ctl.alu_src_a;
  assign alu_src_b  = ctl.alu_src_b;
  assign alu_op     = ctl.alu_op;
  assign mem_to_reg = ctl.mem_to_reg;
  assign epc_wr     = ctl.epc_wr;
  assign cause_wr   = ctl.cause_wr;
  assign cause_code = ctl.cause_code;
  assign state      = cur;
  assign pc_load    = ctl.pc_wr | (ctl.pc_wr_cond & alu_zero);

  // R1
  rst_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> state == ST_FETCH);

  // R8
  beq_hold_chk: assert property (@(posedge clk) disable iff (!run)
    (cur == ST_BEQ && !alu_zero) |-> !pc_load);

  // R11
  ovf_no_wb_chk: assert property (@(posedge clk) disable iff (!run)
    (cur == ST_REXE && alu_ovf) |=> !reg_wr);
endmodule

// File: tb/tb_mc_ctrl.sv
module tb_mc_ctrl;
  import mc_ctrl_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic       alu_zero, alu_ovf;
  logic       pc_load, pc_wr, pc_wr_cond, ir_wr, reg_wr, reg_dst;
  logic       mem_rd, mem_wr, iord, alu_src_a, mem_to_reg, epc_wr, cause_wr;
  logic [1:0] pc_src, alu_op, cause_code;
  logic [2:0] alu_src_b;
  logic [3:0] state;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
    .alu_ovf(alu_ovf), .pc_load(pc_load), .pc_wr(pc_wr),
    .pc_wr_cond(pc_wr_cond), .pc_src(pc_src), .ir_wr(ir_wr),
    .reg_wr(reg_wr), .reg_dst(reg_dst), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .iord(iord), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
    .alu_op(alu_op), .mem_to_reg(mem_to_reg), .epc_wr(epc_wr),
    .cause_wr(cause_wr), .cause_code(cause_code), .state(state));

  function automatic logic [21:0] act_vec();
    return {pc_load, pc_wr, pc_wr_cond, pc_src, ir_wr, reg_wr, reg_dst,
            mem_rd, mem_wr, iord, alu_src_a, alu_src_b, alu_op, mem_to_reg,
            epc_wr, cause_wr, cause_code};
  endfunction

  function automatic logic [8:0] strobes();
    return {pc_load, pc_wr, pc_wr_cond, ir_wr, reg_wr, mem_rd, mem_wr,
            epc_wr, cause_wr};
  endfunction

  // expected control word from the requirement table
  function automatic logic [21:0] exp_vec(logic [3:0] st, logic z);
    logic pw = 0, pwc = 0, irw = 0, rw = 0, rd = 0, mr = 0, mw = 0, io = 0;
    logic sa = 0, m2r = 0, ew = 0, cw = 0;
    logic [1:0] ps = 0, op = 0, cc = 0;
    logic [2:0] sb = 0;
    case (st)
      4'b0000: begin mr = 1; irw = 1; sb = 1; pw = 1; end
      4'b0001: sb = 3;
      4'b0010: begin sa = 1; op = 1; pwc = 1; ps = 1; end
      4'b0100: begin sa = 1; op = 2; end
      4'b0101: begin rw = 1; rd = 1; end
      4'b0110: begin sa = 1; sb = 4; op = 3; end
      4'b0111: rw = 1;
      4'b1000, 4'b1011: begin sa = 1; sb = 2; end
      4'b1001: begin mr = 1; io = 1; end
      4'b1010: begin rw = 1; m2r = 1; end
      4'b1100: begin mw = 1; io = 1; end
      4'b1101, 4'b1110: begin
        sb = 1; op = 1; ew = 1; cw = 1; ps = 2; pw = 1;
        cc = (st == 4'b1110) ? 2'd1 : 2'd0;
      end
      default: ;
    endcase
    return {pw | (pwc & z), pw, pwc, ps, irw, rw, rd, mr, mw, io, sa, sb, op,
            m2r, ew, cw, cc};
  endfunction

  function automatic string req_of(logic [3:0] st);
    case (st)
      4'b0000: return "R2";
      4'b0001: return "R3";
      4'b0010: return "R8";
      4'b0100, 4'b0101: return "R4";
      4'b0110, 4'b0111: return "R5";
      4'b1000, 4'b1001, 4'b1010: return "R6";
      4'b1011, 4'b1100: return "R7";
      4'b1101: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // run one instruction from fetch; currently at a negedge in fetch
  task automatic run_instr(input logic [5:0] opc, input logic flg);
    logic [3:0] seq [0:4];
    int len;
    opcode = opc; alu_ovf = flg; alu_zero = flg;
    seq[0] = 4'b0000; seq[1] = 4'b0001;
    case (opc)
      6'd0:  begin seq[2] = 4'b0100; seq[3] = flg ? 4'b1110 : 4'b0101; len = 4; end
      6'd13: begin seq[2] = 4'b0110; seq[3] = 4'b0111; len = 4; end
      6'd35: begin seq[2] = 4'b1000; seq[3] = 4'b1001; seq[4] = 4'b1010; len = 5; end
      6'd43: begin seq[2] = 4'b1011; seq[3] = 4'b1100; len = 4; end
      6'd4:  begin seq[2] = 4'b0010; len = 3; end
      default: begin seq[2] = 4'b1101; len = 3; end
    endcase
    for (int k = 0; k < len; k++) begin
      chk(state == seq[k], (k == 2) ? "R3" : "R9", "state",
          32'(state), 32'(seq[k]));
      chk(act_vec() == exp_vec(seq[k], flg), req_of(seq[k]), "controls",
          32'(act_vec()), 32'(exp_vec(seq[k], flg)));
      // R13 read and write exclusive
      chk(!(mem_rd && mem_wr), "R13", "mem rd/wr", 32'({mem_rd, mem_wr}), 32'd0);
      step();
    end
    // R12 return to fetch after the last state, giving the R9 length
    chk(state == 4'b0000, "R12", "return state", 32'(state), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; opcode = '0; alu_zero = 0; alu_ovf = 0;
    #1;
    // R1 during reset
    chk(state == 4'b0000, "R1", "reset state", 32'(state), 32'd0);
    chk(strobes() == 9'd0, "R1", "reset strobes", 32'(strobes()), 32'd0);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk(strobes() == 9'd0, "R1", "strobes one edge after release",
        32'(strobes()), 32'd0);
    step();
    chk(act_vec() == exp_vec(4'b0000, 0), "R1", "fetch live after sync",
        32'(act_vec()), 32'(exp_vec(4'b0000, 0)));

    for (int f = 0; f < 2; f++)
      for (int o = 0; o < 64; o++)
        run_instr(6'(o), f[0]);

    // R1 reset mid-load
    opcode = 6'd35; alu_ovf = 0; alu_zero = 0;
    repeat (3) step();
    chk(state == 4'b1001, "R6", "load mem state", 32'(state), 32'd9);
    #1 rst_n = 1'b0;
    #1;
    chk(state == 4'b0000, "R1", "async reset state", 32'(state), 32'd0);
    chk(strobes() == 9'd0, "R1", "async reset strobes", 32'(strobes()), 32'd0);
    @(negedge clk);
    step();
    rst_n = 1'b1;
    step();
    chk(strobes() == 9'd0, "R1", "gated after release", 32'(strobes()), 32'd0);
    step();
    chk(state == 4'b0000 && pc_wr && ir_wr, "R1", "fetch after resync",
        32'(state), 32'd0);
    run_instr(6'd35, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule